// File: doc/BRIEF.md
# Bitwise Non-Destructive Bus Arbiter

This block is the transmit-side arbitration unit of a node on a wired-AND serial bus. On this bus a driven 0 is dominant and a released 1 is recessive. A frame starts with one start-of-frame slot, in which the node drives dominant. After that the node drives one frame bit per slot. At each bit strobe it compares the value it drove with the bus value sampled for that slot.

If the node drove recessive but the bus reads dominant, another node is sending a lower-valued frame. The node then drops out at once, releases the bus and raises a retry request. It waits for an idle bus and then sends the whole frame again. The winning frame passes through undamaged. When frames are sent most significant bit first, the frame with the lowest binary value wins, whatever the number of priority bits.

If the node drove dominant but reads recessive, the bus itself is faulty. This is reported as a bus error, not as lost arbitration. The frame is dropped and sent again once the bus is idle.

Bit timing and symbol encoding belong to a separate stage. This block sees only one strobe per bit slot, the bit to send and the sampled bus bit. It presents the index of the frame bit it wants next, so that a frame source can supply that bit.

Top module: `bus_arbiter`

## Requirements
- R1: After reset, bus_drive is 1 (recessive), and tx_busy, retry_req, arb_lost, bus_err and frame_done are all 0.
- R2: A frame starts only on a bit_tick while tx_req and bus_idle are both 1. The node then enters the start-of-frame slot and raises tx_busy. In that slot bus_drive is 0 (dominant) and the bus is not compared.
- R3: In each data slot bus_drive equals tx_bit, and bit_idx counts 0 to FRAME_BITS-1. Comparison starts with the first slot after start-of-frame. When nodes start together and send most significant bit first, the lowest-valued frame completes first. Equal frames complete together. A node loses once for every distinct lower value among the competing frames.
- R4: In a data slot, a bit_tick that finds tx_bit=1 and bus_rx=0 is a loss. In the next cycle arb_lost pulses for one cycle, and tx_busy falls. bus_drive is 1 from then until the next start of frame.
- R5: In a data slot, a bit_tick that finds tx_bit=0 and bus_rx=1 makes bus_err pulse for one cycle instead of arb_lost. The frame is abandoned and retried once the bus is idle.
- R6: After a loss, retry_req stays 1 and no frame starts while bus_idle is 0. The first bit_tick with bus_idle=1 starts the same frame again.
- R7: frame_done pulses for one cycle after the bit_tick of bit FRAME_BITS-1 passes without loss or error. At most one of arb_lost, bus_err and frame_done is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_req | input | 1 | Node has a frame to send (held until frame_done) |
| bit_tick | input | 1 | One-cycle strobe at the sample point of each bit slot |
| tx_bit | input | 1 | Frame bit at index bit_idx |
| bus_rx | input | 1 | Bus value sampled for the current slot |
| bus_idle | input | 1 | Bus is free for a new frame |
| bus_drive | output | 1 | Drive onto the wired-AND bus, 0 dominant |
| bit_idx | output | $clog2(FRAME_BITS) | Index of the frame bit in the current data slot |
| tx_busy | output | 1 | Start-of-frame or data slot in progress |
| arb_lost | output | 1 | One-cycle pulse on lost arbitration |
| bus_err | output | 1 | One-cycle pulse on dominant driven but recessive read |
| frame_done | output | 1 | One-cycle pulse when a frame completes |
| retry_req | output | 1 | Lost arbitration, waiting for idle to retry |

## Verification
The hardest situation to reach is a loser that holds its retry while the bus stays busy. On a healthy bus the winner ends its frame and idle returns on its own. The bench therefore holds its idle line low as soon as a loss appears, and checks that the loser neither starts nor drops its request. A bus error cannot occur on a healthy wired-AND bus, so the bench forces the bus recessive under a node that drives dominant. The main sweep runs three nodes on a modelled wired-AND bus over all pairs of 4-bit frames, with a derived third frame. The expected order of completion and the number of losses for each node follow from the frame values alone.

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int FRAME_BITS = 16,
  parameter int ARB_BITS   = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tx_req,
  input  logic                          bit_tick,
  input  logic                          tx_bit,
  input  logic                          bus_rx,
  input  logic                          bus_idle,
  output logic                          bus_drive,
  output logic [$clog2(FRAME_BITS)-1:0] bit_idx,
  output logic                          tx_busy,
  output logic                          arb_lost,
  output logic                          bus_err,
  output logic                          frame_done,
  output logic                          retry_req
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST = IW'(FRAME_BITS - 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SOF, S_ARB, S_TX, S_LOST} st_t;

  st_t st;
  logic [IW-1:0] idx;
  logic lost_q, err_q, done_q;

  wire data_slot = (st == S_ARB) || (st == S_TX);
  wire loss      = bit_tick && data_slot && tx_bit && !bus_rx;
  wire clash     = bit_tick && data_slot && !tx_bit && bus_rx;

  assign bus_drive  = (st == S_SOF) ? 1'b0 : (data_slot ? tx_bit : 1'b1);
  assign tx_busy    = (st == S_SOF) || data_slot;
  assign retry_req  = (st == S_LOST);
  assign bit_idx    = idx;
  assign arb_lost   = lost_q;
  assign bus_err    = err_q;
  assign frame_done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      lost_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      lost_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      case (st)
        S_IDLE, S_WAIT, S_LOST: begin
          if (!tx_req)                 st <= S_IDLE;
          else if (bit_tick && bus_idle) st <= S_SOF;
          else if (st == S_IDLE)       st <= S_WAIT;
        end
        S_SOF: if (bit_tick) begin
          st  <= S_ARB;
          idx <= '0;
        end
        S_ARB, S_TX: if (bit_tick) begin
          if (loss) begin
            st     <= S_LOST;
            lost_q <= 1'b1;
          end else if (clash) begin
            st    <= S_WAIT;
            err_q <= 1'b1;
          end else if (idx == LAST) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            st  <= ((int'(idx) + 1) < ARB_BITS) ? S_ARB : S_TX;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_loss_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && data_slot && tx_bit && !bus_rx) |=> (arb_lost && bus_drive && !tx_busy && retry_req));

  a_r5_err_not_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && data_slot && !tx_bit && bus_rx) |=> (bus_err && !arb_lost && !tx_busy));

  a_r6_gate_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_req && !(bit_tick && bus_idle)) |=> !tx_busy);

  a_r2_sof_dominant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !bus_drive);

  a_r7_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arb_lost, bus_err, frame_done}));

  a_r7_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!tx_busy && !retry_req));
endmodule

// File: tb/bus_arbiter_bench.sv
module bus_arbiter_bench;
  localparam int FB = 4;
  localparam int AB = 2;
  localparam int NN = 3;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tick, force_hi, force_busy;
  logic [NN-1:0] req;
  logic [FB-1:0] frame [NN];
  logic [NN-1:0] drv, busy, lost, err, done, retry;
  logic [1:0] idx [NN];

  wire bus_rx = (&drv) | force_hi;
  wire idle   = ~(|busy) & ~force_busy;

  for (genvar i = 0; i < NN; i++) begin : g_node
    bus_arbiter #(.FRAME_BITS(FB), .ARB_BITS(AB)) u_bus_arbiter (
      .clk(clk), .rst_n(rst_n), .tx_req(req[i]), .bit_tick(tick),
      .tx_bit(frame[i][FB-1-idx[i]]), .bus_rx(bus_rx), .bus_idle(idle),
      .bus_drive(drv[i]), .bit_idx(idx[i]), .tx_busy(busy[i]),
      .arb_lost(lost[i]), .bus_err(err[i]), .frame_done(done[i]),
      .retry_req(retry[i]));
  end

  int cyc = 0, nchk = 0, nfail = 0;
  bit timed_out = 0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    tick = (cyc % 2 == 0);
    if (cyc > LIMIT) timed_out = 1;
  endtask

  task automatic run3(input logic [FB-1:0] a, input logic [FB-1:0] b, input logic [FB-1:0] c);
    int lc[NN], dt[NN], ec, n, exp_l;
    logic [FB-1:0] v[NN];
    v[0] = a; v[1] = b; v[2] = c;
    for (int i = 0; i < NN; i++) begin lc[i] = 0; dt[i] = -1; frame[i] = v[i]; end
    ec = 0; n = 0;
    req = '1;
    while (req != 0 && n < 300 && !timed_out) begin
      step(); n++;
      for (int i = 0; i < NN; i++) begin
        if (lost[i]) begin
          lc[i]++;
          chk(drv[i] && retry[i], "R4 release and retry after loss", {drv[i], retry[i]}, 3);
        end
        if (err[i]) ec++;
        if (done[i]) begin dt[i] = cyc; req[i] = 1'b0; end
      end
    end
    chk(req == 0, "R7 all frames complete", int'(req), 0);
    chk(ec == 0, "R5 no bus error on healthy bus", ec, 0);
    for (int i = 0; i < NN; i++) begin
      exp_l = 0;
      for (int j = 0; j < NN; j++) begin
        bit dup = 0;
        for (int k = 0; k < j; k++) if (v[k] == v[j]) dup = 1;
        if (j != i && !dup && v[j] < v[i]) exp_l++;
      end
      chk(lc[i] == exp_l, "R3 losses per node", lc[i], exp_l);
      for (int j = i + 1; j < NN; j++) begin
        bit ok;
        ok = (v[i] < v[j]) ? (dt[i] < dt[j]) : (v[i] > v[j]) ? (dt[i] > dt[j]) : (dt[i] == dt[j]);
        chk(ok, "R3 completion order", dt[i], dt[j]);
      end
    end
    req = '0;
    repeat (4) step();
  endtask

  initial begin
    int n, ec, lc;
    bit ok;
    rst_n = 1'b0; tick = 1'b0; force_hi = 1'b0; force_busy = 1'b0; req = '0;
    for (int i = 0; i < NN; i++) frame[i] = '0;
    repeat (3) step();
    for (int i = 0; i < NN; i++)
      chk(drv[i] && !busy[i] && !retry[i] && !lost[i] && !err[i] && !done[i],
          "R1 reset state", {drv[i], busy[i], retry[i]}, 4);
    rst_n = 1'b1;
    repeat (2) step();

    // R2: start gated on idle, start-of-frame slot dominant
    frame[0] = 4'b0000; force_busy = 1'b1; force_hi = 1'b1;
    req[0] = 1'b1;
    ok = 1;
    repeat (10) begin step(); if (busy[0]) ok = 0; end
    chk(ok, "R2 no start while bus busy", int'(busy[0]), 0);
    force_busy = 1'b0;
    n = 0;
    while (!busy[0] && n < 10) begin step(); n++; end
    chk(busy[0] && !drv[0], "R2 start-of-frame drives dominant", drv[0], 0);
    // R5: dominant driven, recessive read
    ec = 0; lc = 0; n = 0;
    while (ec == 0 && n < 40) begin
      step(); n++;
      if (err[0]) ec++;
      if (lost[0]) lc++;
    end
    chk(ec == 1 && lc == 0, "R5 bus error not loss", lc, 0);
    force_hi = 1'b0;
    n = 0;
    while (!done[0] && n < 60) begin step(); n++; if (err[0]) ec++; end
    chk(done[0] && ec == 1, "R5 retried frame completes", ec, 1);
    req = '0;
    repeat (4) step();

    // R6: loser holds retry while idle withheld
    frame[0] = 4'b0001; frame[1] = 4'b0010;
    req = 3'b011;
    n = 0;
    while (!lost[1] && n < 40) begin step(); n++; end
    chk(lost[1] == 1'b1, "R4 loser sees loss", int'(lost[1]), 1);
    force_busy = 1'b1;
    ok = 1; lc = 0;
    repeat (40) begin
      step();
      if (done[0]) begin req[0] = 1'b0; lc++; end
      if (!retry[1] || busy[1] || !drv[1]) ok = 0;
    end
    chk(ok, "R6 retry held while bus busy", int'(retry[1]), 1);
    chk(lc == 1, "R7 winner completes once", lc, 1);
    force_busy = 1'b0;
    n = 0;
    while (!done[1] && n < 60) begin step(); n++; end
    chk(done[1] == 1'b1, "R6 loser retries after idle", int'(done[1]), 1);
    req = '0;
    repeat (4) step();

    // R3 sweep over frame pairs with derived third frame
    for (int a = 0; a < 16 && !timed_out; a++)
      for (int b = 0; b < 16 && !timed_out; b++)
        run3(4'(a), 4'(b), 4'((a + 3 * b + 7) % 16));

    if (timed_out) chk(0, "watchdog", cyc, LIMIT);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule